// File: doc/BRIEF.md
# Set-Associative Read Cache with Use-Bit Replacement

This block is a small read-only cache that sits in front of a word-wide memory port. It holds eight blocks of four 32-bit words, for 128 bytes in all. A parameter sets how those eight blocks are grouped: 1, 2 or 4 ways. Fewer sets mean fewer index bits and more tag bits. On each lookup the tags of every way in the chosen set are compared in parallel.

On a miss the controller picks a way to load. It fetches the whole block from memory one word at a time, lowest word first, and then returns the requested word. Each block carries one use bit, which approximates recency. A hit or a fill sets the bit. A free-running count of accepted requests clears all use bits at a fixed period. When a set is full, the way chosen for eviction is one whose use bit is clear.

A requester presents an address while `ready_o` is high and gets exactly one response later, flagged as hit or miss.

Top module: `sa_read_cache`

## Requirements
- R1: A request address is 10 bits wide. Bits [1:0] are the byte offset and are ignored. Bits [3:2] select one of four words. The next log2(8/WAYS) bits form the set index. The remaining upper bits form the tag.
- R2: After reset, `ready_o` is 1, `resp_valid_o` is 0 and `mem_req_o` is 0. Every block is invalid, so the first access to any address misses.
- R3: An access hits when a valid way of the indexed set holds its tag. The response then comes in the cycle after acceptance, with `resp_hit_o`=1 and the addressed word, and no memory read is made. At most one way of a set ever matches.
- R4: On a miss the block is read with four word requests. Each request has `mem_addr_o` = {address[9:4], word, 2'b00}, with word counting 0,1,2,3. `mem_req_o` and the address are held until `mem_valid_i`. The response, with `resp_hit_o`=0 and the addressed word, comes in the cycle after the last word returns.
- R5: When the indexed set has an invalid way, the fill goes to the lowest-numbered invalid way, and no valid block is evicted.
- R6: When every way of the set is valid, the victim is the lowest-numbered way whose use bit is clear. If all use bits of the set are set, way 0 is evicted.
- R7: A hit sets the use bit of the block that hit. A fill sets the use bit of the block that was loaded.
- R8: Every CLEAR_PERIOD-th accepted request (counted from reset) clears all use bits as it is accepted, before its own lookup.
- R9: Take the addresses 0100111000, 1100110100, 0100111100, 0110110000, 1100111000 in that order, from reset. With 4 ways they give miss, miss, hit, miss, hit. With 1 way they give five misses.
- R10: A request is taken only while `ready_o` is 1. `ready_o` is 1 only while the controller is idle, never alongside a response or a memory request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 10 | Request byte address |
| ready_o | output | 1 | Controller idle, request accepted this cycle if valid |
| resp_valid_o | output | 1 | Response present for one cycle |
| resp_hit_o | output | 1 | Response came from a hit |
| resp_data_o | output | 32 | Requested word |
| mem_req_o | output | 1 | Word read request to memory |
| mem_addr_o | output | 10 | Byte address of the requested word |
| mem_valid_i | input | 1 | Memory returns the requested word |
| mem_data_i | input | 32 | Returned word |

## Verification
Some properties are checked on every cycle:
- at most one way matches;
- the victim is an invalid way when one exists, or else a way with a clear use bit;
- the periodic tick leaves all use bits clear;
- a hit or fill marks its block;
- hit responses follow acceptance directly;
- the memory address stays stable while a word is outstanding.

Other behaviour only shows over a whole scenario, because a single cycle cannot reveal it:
- which block was actually evicted;
- how hit and miss results fall out across an address sequence for different associativities;
- how a periodic clear changes a later eviction.

The bench exposes all of this through later hits and misses.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  localparam int unsigned ADDR_W     = 10;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BYTE_OFF_W = 2;
  localparam int unsigned BLK_OFF_W  = 2;
  localparam int unsigned BLK_WORDS  = 1 << BLK_OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL,
    ST_RESP
  } ctrl_state_e;
endpackage

// File: rtl/sa_tag_match.sv
module sa_tag_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [TAG_W-1:0]               tag_i,
  input  logic [WAYS-1:0][TAG_W-1:0]     way_tag_i,
  input  logic [WAYS-1:0]                way_valid_i,
  output logic                           hit_o,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0] hit_way_o
);
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0] hit_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_valid_i[g] && (way_tag_i[g] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o = |hit_vec;

  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R3
endmodule

// File: rtl/sa_victim_pick.sv
module sa_victim_pick #(
  parameter int unsigned WAYS = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [WAYS-1:0]                       valid_i,
  input  logic [WAYS-1:0]                       use_i,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0]  victim_o
);
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic picked;

  // priority: lowest invalid, then lowest unused, then way 0
  always_comb begin
    victim_o = '0;
    picked   = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!picked && !valid_i[w]) begin
        victim_o = WAY_W'(w);
        picked   = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!picked && !use_i[w]) begin
        victim_o = WAY_W'(w);
        picked   = 1'b1;
      end
    end
  end

  AST_FILL_EMPTY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid_i) |-> !valid_i[victim_o]); // R5
  AST_EVICT_UNUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&valid_i) && !(&use_i)) |-> !use_i[victim_o]); // R6
endmodule

// File: rtl/sa_use_tracker.sv
module sa_use_tracker #(
  parameter int unsigned NUM_BLOCKS   = 8,
  parameter int unsigned CLEAR_PERIOD = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          access_i,
  input  logic                          set_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] set_blk_i,
  output logic [NUM_BLOCKS-1:0]         use_o
);
  localparam int unsigned CNT_W = (CLEAR_PERIOD > 1) ? $clog2(CLEAR_PERIOD) : 1;

  logic [CNT_W-1:0]      cnt_q;
  logic [NUM_BLOCKS-1:0] use_q;
  logic                  tick;

  assign tick = access_i && (cnt_q == CNT_W'(CLEAR_PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (access_i) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_q <= '0;
    end else if (tick) begin
      use_q <= '0;
    end else if (set_i) begin
      use_q[set_blk_i] <= 1'b1;
    end
  end

  assign use_o = use_q;

  AST_PERIOD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (use_o == '0)); // R8
  AST_USE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !tick) |=> use_o[$past(set_blk_i)]); // R7
endmodule

// File: rtl/sa_line_store.sv
module sa_line_store
  import sa_cache_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 8,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned TAG_W      = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [$clog2(NUM_BLOCKS)-1:0] rd_base_i,
  output logic [WAYS-1:0][TAG_W-1:0]    set_tag_o,
  output logic [WAYS-1:0]               set_valid_o,
  input  logic [$clog2(NUM_BLOCKS)-1:0] rd_blk_i,
  input  logic [BLK_OFF_W-1:0]          rd_word_i,
  output logic [WORD_W-1:0]             rd_data_o,
  input  logic                          wr_en_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] wr_blk_i,
  input  logic [BLK_OFF_W-1:0]          wr_word_i,
  input  logic [WORD_W-1:0]             wr_data_i,
  input  logic                          commit_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] commit_blk_i,
  input  logic [TAG_W-1:0]              commit_tag_i
);
  localparam int unsigned BLK_W = $clog2(NUM_BLOCKS);

  logic [NUM_BLOCKS-1:0][TAG_W-1:0] tags_q;
  logic [NUM_BLOCKS-1:0]            valid_q;
  logic [WORD_W-1:0]                data_q [NUM_BLOCKS][BLK_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tags_q  <= '0;
      valid_q <= '0;
    end else if (commit_i) begin
      tags_q[commit_blk_i]  <= commit_tag_i;
      valid_q[commit_blk_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_blk_i][wr_word_i] <= wr_data_i;
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_set_rd
    assign set_tag_o[g]   = tags_q[rd_base_i | BLK_W'(g)];
    assign set_valid_o[g] = valid_q[rd_base_i | BLK_W'(g)];
  end

  assign rd_data_o = data_q[rd_blk_i][rd_word_i];

  AST_COMMIT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> valid_q[$past(commit_blk_i)]); // R4
endmodule

// File: rtl/sa_read_cache.sv
module sa_read_cache
  import sa_cache_pkg::*;
#(
  parameter int unsigned WAYS         = 4,
  parameter int unsigned NUM_BLOCKS   = 8,
  parameter int unsigned CLEAR_PERIOD = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [WORD_W-1:0] resp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_data_i
);
  localparam int unsigned SETS   = NUM_BLOCKS / WAYS;
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned LOW_W  = BYTE_OFF_W + BLK_OFF_W;
  localparam int unsigned TAG_W  = ADDR_W - LOW_W - IDX_W;
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned WAY_SH = $clog2(WAYS);
  localparam int unsigned BLK_W  = $clog2(NUM_BLOCKS);

  ctrl_state_e          state_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [BLK_OFF_W-1:0] word_cnt_q;
  logic [WAY_W-1:0]     victim_q;

  logic [TAG_W-1:0]     tag_q;
  logic [IDX_W-1:0]     idx_q;
  logic [BLK_OFF_W-1:0] woff_q;
  logic [BLK_W-1:0]     base_blk, hit_blk, fill_blk;

  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAYS-1:0]            set_valid, set_use;
  logic [NUM_BLOCKS-1:0]      use_all;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way, victim;
  logic                       accept, lookup_hit, fill_wr, fill_last;
  logic [WORD_W-1:0]          rd_data;

  assign tag_q  = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_q  = addr_q[LOW_W +: IDX_W];
  assign woff_q = addr_q[BYTE_OFF_W +: BLK_OFF_W];

  // block number = set * WAYS + way
  assign base_blk = BLK_W'(idx_q) << WAY_SH;
  assign hit_blk  = base_blk | BLK_W'(hit_way);
  assign fill_blk = base_blk | BLK_W'(victim_q);

  assign accept     = req_valid_i && (state_q == ST_IDLE);
  assign lookup_hit = (state_q == ST_LOOKUP) && hit;
  assign fill_wr    = (state_q == ST_FILL) && mem_valid_i;
  assign fill_last  = fill_wr && (word_cnt_q == BLK_OFF_W'(BLK_WORDS - 1));

  for (genvar g = 0; g < WAYS; g++) begin : g_set_use
    assign set_use[g] = use_all[base_blk | BLK_W'(g)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      word_cnt_q <= '0;
      victim_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            state_q <= ST_IDLE;
          end else begin
            victim_q   <= victim;
            word_cnt_q <= '0;
            state_q    <= ST_FILL;
          end
        end
        ST_FILL: if (mem_valid_i) begin
          word_cnt_q <= word_cnt_q + 1'b1;
          if (fill_last) state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sa_line_store #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .WAYS       (WAYS),
    .TAG_W      (TAG_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_base_i    (base_blk),
    .set_tag_o    (set_tag),
    .set_valid_o  (set_valid),
    .rd_blk_i     ((state_q == ST_LOOKUP) ? hit_blk : fill_blk),
    .rd_word_i    (woff_q),
    .rd_data_o    (rd_data),
    .wr_en_i      (fill_wr),
    .wr_blk_i     (fill_blk),
    .wr_word_i    (word_cnt_q),
    .wr_data_i    (mem_data_i),
    .commit_i     (fill_last),
    .commit_blk_i (fill_blk),
    .commit_tag_i (tag_q)
  );

  sa_tag_match #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W)
  ) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tag_i       (tag_q),
    .way_tag_i   (set_tag),
    .way_valid_i (set_valid),
    .hit_o       (hit),
    .hit_way_o   (hit_way)
  );

  sa_victim_pick #(
    .WAYS (WAYS)
  ) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (set_valid),
    .use_i    (set_use),
    .victim_o (victim)
  );

  sa_use_tracker #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .CLEAR_PERIOD (CLEAR_PERIOD)
  ) u_use (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .access_i  (accept),
    .set_i     (lookup_hit || fill_last),
    .set_blk_i (lookup_hit ? hit_blk : fill_blk),
    .use_o     (use_all)
  );

  assign ready_o      = (state_q == ST_IDLE);
  assign resp_valid_o = lookup_hit || (state_q == ST_RESP);
  assign resp_hit_o   = (state_q == ST_LOOKUP);
  assign resp_data_o  = rd_data;
  assign mem_req_o    = (state_q == ST_FILL);
  assign mem_addr_o   = {addr_q[ADDR_W-1:LOW_W], word_cnt_q, {BYTE_OFF_W{1'b0}}};

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_hit_o) |-> $past(req_valid_i && ready_o)); // R3
  AST_MISS_AFTER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |-> $past(mem_req_o && mem_valid_i)); // R4
  AST_MEM_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R4
  AST_READY_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!resp_valid_o && !mem_req_o)); // R10
endmodule

// File: tb/sa_read_cache_tb_top.sv
module sa_read_cache_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel = 1'b0;
  logic       req_valid = 1'b0;
  logic [9:0] req_addr = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;

  function automatic logic [31:0] mem_word(input logic [9:0] a);
    return 32'h5EED_0000 ^ {22'b0, a};
  endfunction

  function automatic logic [9:0] mk(input logic [4:0] tag, input logic s, input logic [1:0] w);
    return {tag, s, w, 2'b00};
  endfunction

  // 4-way instance
  logic        a_ready, a_rv, a_hit, a_mreq;
  logic [31:0] a_data, a_mdata;
  logic [9:0]  a_maddr;
  assign a_mdata = mem_word(a_maddr);

  sa_read_cache #(.WAYS(4), .NUM_BLOCKS(8), .CLEAR_PERIOD(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid && !sel), .req_addr_i(req_addr),
    .ready_o(a_ready), .resp_valid_o(a_rv), .resp_hit_o(a_hit), .resp_data_o(a_data),
    .mem_req_o(a_mreq), .mem_addr_o(a_maddr), .mem_valid_i(a_mreq), .mem_data_i(a_mdata)
  );

  // direct-mapped instance
  logic        d_ready, d_rv, d_hit, d_mreq;
  logic [31:0] d_data, d_mdata;
  logic [9:0]  d_maddr;
  assign d_mdata = mem_word(d_maddr);

  sa_read_cache #(.WAYS(1), .NUM_BLOCKS(8), .CLEAR_PERIOD(8)) dut_dm_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid && sel), .req_addr_i(req_addr),
    .ready_o(d_ready), .resp_valid_o(d_rv), .resp_hit_o(d_hit), .resp_data_o(d_data),
    .mem_req_o(d_mreq), .mem_addr_o(d_maddr), .mem_valid_i(d_mreq), .mem_data_i(d_mdata)
  );

  logic        s_ready, s_rv, s_hit, s_mreq;
  logic [31:0] s_data;
  logic [9:0]  s_maddr;
  assign s_ready = sel ? d_ready : a_ready;
  assign s_rv    = sel ? d_rv    : a_rv;
  assign s_hit   = sel ? d_hit   : a_hit;
  assign s_data  = sel ? d_data  : a_data;
  assign s_mreq  = sel ? d_mreq  : a_mreq;
  assign s_maddr = sel ? d_maddr : a_maddr;

  typedef struct {
    logic [9:0] a;
    bit         hit;
    string      rq;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  // driver: push expectation, then present request
  task automatic access(input logic [9:0] a, input bit eh, input string rq);
    exp_t e;
    e.a = a; e.hit = eh; e.rq = rq;
    @(posedge clk_i); #1;
    while (!s_ready) begin @(posedge clk_i); #1; end
    sb_q.push_back(e);
    req_addr  = a;
    req_valid = 1'b1;
    @(posedge clk_i); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(posedge clk_i);
    @(posedge clk_i);
  endtask

  task automatic do_reset();
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(a_ready == 1'b1 && d_ready == 1'b1, "R2", "ready after reset", {a_ready, d_ready}, 2'b11);
    chk(!a_rv && !d_rv, "R2", "resp_valid after reset", {a_rv, d_rv}, 0);
    chk(!a_mreq && !d_mreq, "R2", "mem_req after reset", {a_mreq, d_mreq}, 0);
  endtask

  // monitor: latency, word order, hit flag and data
  int  lat  = 0;
  int  wcnt = 0;
  bit  pend = 1'b0;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      pend = 1'b0; lat = 0; wcnt = 0;
    end else begin
      if (pend) lat++;
      if (s_mreq) begin
        if (sb_q.size() > 0)
          chk(s_maddr == {sb_q[0].a[9:4], wcnt[1:0], 2'b00}, "R4", "fill word address",
              s_maddr, {sb_q[0].a[9:4], wcnt[1:0], 2'b00});
        wcnt++;
      end
      if (s_rv) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(s_hit == e.hit, e.rq, $sformatf("hit flag addr %b", e.a), s_hit, e.hit);
          chk(s_data == mem_word({e.a[9:2], 2'b00}), e.rq, $sformatf("data addr %b", e.a),
              s_data, mem_word({e.a[9:2], 2'b00}));
          chk(lat == (e.hit ? 1 : 6), e.hit ? "R3" : "R4", "response latency", lat, e.hit ? 1 : 6);
          chk(wcnt == (e.hit ? 0 : 4), e.hit ? "R3" : "R4", "memory words read", wcnt, e.hit ? 0 : 4);
        end
        pend = 1'b0; lat = 0; wcnt = 0;
      end
      if (req_valid && s_ready) begin
        pend = 1'b1; lat = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R10 watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R9 / R1: direct-mapped sequence
    sel = 1'b1;
    do_reset();
    access(10'b0100111000, 0, "R9");
    access(10'b1100110100, 0, "R9");
    access(10'b0100111100, 0, "R9");
    access(10'b0110110000, 0, "R9");
    access(10'b1100111000, 0, "R9");
    access(10'b1100111011, 1, "R1");  // byte offset ignored
    drain();

    // R9: 4-way sequence, then set independence
    sel = 1'b0;
    do_reset();
    access(10'b0100111000, 0, "R9");
    access(10'b1100110100, 0, "R9");
    access(10'b0100111100, 1, "R9");
    access(10'b0110110000, 0, "R9");
    access(10'b1100111000, 1, "R9");
    access(10'b0100101000, 0, "R1");  // same tag, other set
    access(10'b0100111000, 1, "R3");
    drain();

    // R5 R6 R7 R8: use-bit replacement in set 0, clear every 8th access
    do_reset();
    access(mk(5'd1, 0, 2'd0), 0, "R2");   // 1 A -> w0
    access(mk(5'd2, 0, 2'd1), 0, "R5");   // 2 B -> w1
    access(mk(5'd3, 0, 2'd2), 0, "R5");   // 3 C -> w2
    access(mk(5'd4, 0, 2'd3), 0, "R5");   // 4 D -> w3
    access(mk(5'd2, 0, 2'd0), 1, "R3");   // 5
    access(mk(5'd3, 0, 2'd1), 1, "R3");   // 6
    access(mk(5'd4, 0, 2'd2), 1, "R3");   // 7
    access(mk(5'd4, 0, 2'd3), 1, "R8");   // 8 clear, D marked
    access(mk(5'd2, 0, 2'd1), 1, "R7");   // 9 B marked
    access(mk(5'd5, 0, 2'd0), 0, "R6");   // 10 E evicts A (w0)
    access(mk(5'd6, 0, 2'd2), 0, "R6");   // 11 F evicts C (w2)
    access(mk(5'd2, 0, 2'd3), 1, "R6");   // 12 B kept
    access(mk(5'd4, 0, 2'd0), 1, "R6");   // 13 D kept
    access(mk(5'd6, 0, 2'd1), 1, "R7");   // 14
    access(mk(5'd5, 0, 2'd2), 1, "R7");   // 15
    access(mk(5'd3, 0, 2'd3), 0, "R8");   // 16 clear, C evicts E (w0)
    access(mk(5'd5, 0, 2'd0), 0, "R8");   // 17 E evicts B (w1)
    access(mk(5'd4, 0, 2'd1), 1, "R6");   // 18 D kept
    access(mk(5'd2, 0, 2'd2), 0, "R7");   // 19 B evicts F (w2)
    access(mk(5'd6, 0, 2'd3), 0, "R6");   // 20 F was evicted
    drain();

    // R6: all use bits set -> way 0
    do_reset();
    access(mk(5'd1, 0, 2'd0), 0, "R5");
    access(mk(5'd2, 0, 2'd0), 0, "R5");
    access(mk(5'd3, 0, 2'd0), 0, "R5");
    access(mk(5'd4, 0, 2'd0), 0, "R5");
    access(mk(5'd5, 0, 2'd1), 0, "R6");   // evicts w0
    access(mk(5'd1, 0, 2'd2), 0, "R6");   // evicts w0 again
    access(mk(5'd5, 0, 2'd3), 0, "R6");
    access(mk(5'd2, 0, 2'd1), 1, "R6");
    access(mk(5'd3, 0, 2'd2), 1, "R6");
    access(mk(5'd4, 0, 2'd3), 1, "R6");
    drain();

    chk(sb_q.size() == 0, "R10", "pending responses", sb_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule